// File: doc/BRIEF.md
# Self-Centering Jitter Attenuation FIFO

This block is an elastic bit buffer for one transmit channel. Bits arrive with a gapped or jittery cadence, each one marked by a one-cycle `in_valid` strobe on the fast reference clock. They leave at the rate of a smoothed clock. That clock comes from a divider that normally counts `DIV_NOM` reference cycles per output bit. The block keeps a fill level, which is the write pointer minus the read pointer. It reports underrun and overrun through sticky status bits. Each status bit can drive the interrupt output through its own enable.

Two mechanisms protect the data stream. The first is self-centering. The read pointer is moved to half the depth behind the write pointer. This happens automatically when the fill level comes within a margin of empty or full. It also happens once when software turns the centering enable from 0 to 1. The second is frequency limiting. When the fill level is within one bit of empty, the divider stretches the output period by one reference cycle. When it is within one bit of full, the divider shortens the period by one reference cycle. This lets the buffer ride through large phase excursions without losing bits.

Software sees a small configuration register with these fields:
- bit 0: limit enable
- bit 1: overrun interrupt enable
- bit 2: underrun interrupt enable
- bit 3: centering enable
- bits 7:4: reserved

Software also sees a write-1-to-clear status port.

Top module: `jafifo_top`

## Requirements
- R1: After reset the configuration reads 0x01, meaning only the limit enable is set. The fill level, both status bits, `irq` and `out_bit` are all 0.
- R2: With centering disabled and no underrun or overrun, bits leave in the order they were written. After each clock edge, `fill` equals bits written minus bits read. A read happens on a clock edge where the divider period expires, and `out_tick` pulses in the cycle after that edge. The value read appears on `out_bit` in that same cycle. When a read and a write meet at a full buffer, the read returns the old bit.
- R3: An underrun is a read at fill 0. It moves no pointer, leaves `out_bit` unchanged, and sets status bit 1.
- R4: An overrun is a write at fill `DEPTH` in a cycle without a read. It drops the oldest bit, leaves `fill` at `DEPTH`, and sets status bit 0.
- R5: While the centering enable is 1, the read pointer is moved to `DEPTH/2` behind the write pointer at every edge where the fill before that edge is below `CTR_MARGIN` or above `DEPTH-CTR_MARGIN`. The move happens after that edge's read and write, so `fill` becomes `DEPTH/2`.
- R6: A configuration write that changes the centering enable from 0 to 1 causes one centering at the following edge, at any fill level. Writing 1 again while the enable is already 1 causes no centering.
- R7: The period between read ticks is chosen at each tick from the fill level before that edge. It is `DIV_NOM+1` when limiting is enabled and the fill is at most `LIM_MARGIN`. It is `DIV_NOM-1` when limiting is enabled and the fill is at least `DEPTH-LIM_MARGIN`. Otherwise it is `DIV_NOM`.
- R8: Status bits are sticky. Writing 1 to a bit through `sts_clr` clears it. An event in the same cycle wins over the clear.
- R9: `irq` is 1 exactly when (status bit 0 AND overrun enable) OR (status bit 1 AND underrun enable), evaluated on the values after the same edge.
- R10: Writes to the reserved bits 7:4 have no effect, and those bits always read 0.
- R11: `out_clk` is high for the first P-`DIV_NOM/2` cycles of each output period of length P, counting from the `out_tick` cycle. It is low for the rest of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write strobe for one incoming bit |
| in_bit | input | 1 | Incoming data bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Current configuration, reserved bits 0 |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 2 | Write-1-to-clear mask (bit 0 overrun, bit 1 underrun) |
| sts | output | 2 | Sticky status (bit 0 overrun, bit 1 underrun) |
| fill | output | $clog2(DEPTH)+1 | Fill level after the last edge |
| out_bit | output | 1 | Smoothed output data bit |
| out_tick | output | 1 | One-cycle pulse marking a read |
| out_clk | output | 1 | Smoothed square-wave output clock |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that `in_valid` carries at most one bit per reference cycle. They also assume that configuration writes and status clears are single-cycle strobes that are sampled synchronously with everything else. The stimulus keeps within this by driving every input one cycle at a time between edges. Incoming gaps come from a nominal spacing plus bounded pseudo-random jitter, or from dense bursts of writes. The spacings are chosen so that the buffer drifts toward full, drifts toward empty, or holds near a balance.

// File: rtl/jafifo_pkg.sv
package jafifo_pkg;

  // Control fields, most significant first; bit 0 is the limit enable.
  typedef struct packed {
    logic ctr_en;
    logic und_ie;
    logic ovr_ie;
    logic lim_en;
  } jaf_cfg_t;

  localparam jaf_cfg_t CFG_RESET = '{ctr_en: 1'b0, und_ie: 1'b0, ovr_ie: 1'b0, lim_en: 1'b1};

endpackage

// File: rtl/jafifo_regs.sv
module jafifo_regs
  import jafifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       sts_clr_we,
  input  logic [1:0] sts_clr,
  input  logic       ovr_ev,
  input  logic       und_ev,
  output jaf_cfg_t   cfg_q,
  output logic       ctr_pulse,
  output logic [1:0] sts_q,
  output logic       irq
);

  jaf_cfg_t   cfg_n;
  logic [1:0] clr_mask;
  logic [1:0] sts_n;
  logic [1:0] en_n;

  always_comb begin
    cfg_n    = cfg_we ? jaf_cfg_t'(cfg_wdata[3:0]) : cfg_q;
    clr_mask = sts_clr_we ? sts_clr : 2'b00;
    sts_n    = (sts_q & ~clr_mask) | {und_ev, ovr_ev};
    en_n     = {cfg_n.und_ie, cfg_n.ovr_ie};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= CFG_RESET;
      sts_q     <= 2'b00;
      irq       <= 1'b0;
      ctr_pulse <= 1'b0;
    end else begin
      cfg_q     <= cfg_n;
      sts_q     <= sts_n;
      irq       <= |(sts_n & en_n);
      ctr_pulse <= cfg_we && cfg_wdata[3] && !cfg_q.ctr_en;
    end
  end

  AST_STICKY_OVR: assert property (@(posedge clk) disable iff (rst)
    (sts_q[0] && !(sts_clr_we && sts_clr[0])) |=> sts_q[0]); // R8
  AST_STICKY_UND: assert property (@(posedge clk) disable iff (rst)
    (sts_q[1] && !(sts_clr_we && sts_clr[1])) |=> sts_q[1]); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((sts_q[0] && cfg_q.ovr_ie) || (sts_q[1] && cfg_q.und_ie))); // R9
  AST_PULSE_ENABLED: assert property (@(posedge clk) disable iff (rst)
    ctr_pulse |-> cfg_q.ctr_en); // R6

endmodule

// File: rtl/jafifo_div.sv
module jafifo_div #(
  parameter int DIV_NOM    = 8,
  parameter int DEPTH      = 32,
  parameter int LIM_MARGIN = 1,
  parameter int FW         = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lim_en,
  input  logic [FW-1:0] fill_q,
  output logic          rd_tick,
  output logic          out_clk
);

  localparam int CW = $clog2(DIV_NOM + 2);
  localparam logic [CW-1:0] LOAD_NOM  = CW'(DIV_NOM - 1);
  localparam logic [CW-1:0] LOAD_SLOW = CW'(DIV_NOM);
  localparam logic [CW-1:0] LOAD_FAST = CW'(DIV_NOM - 2);
  localparam logic [CW-1:0] HALF      = CW'(DIV_NOM / 2);
  localparam logic [FW-1:0] LO_EDGE   = FW'(LIM_MARGIN);
  localparam logic [FW-1:0] HI_EDGE   = FW'(DEPTH - LIM_MARGIN);

  logic [CW-1:0] cnt_q, cnt_n, load_v;

  always_comb begin
    if (lim_en && fill_q <= LO_EDGE)      load_v = LOAD_SLOW;
    else if (lim_en && fill_q >= HI_EDGE) load_v = LOAD_FAST;
    else                                  load_v = LOAD_NOM;
    rd_tick = (cnt_q == '0);
    cnt_n   = rd_tick ? load_v : cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= LOAD_NOM;
      out_clk <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      out_clk <= (cnt_n >= HALF);
    end
  end

  AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_tick |=> (cnt_q >= LOAD_FAST && cnt_q <= LOAD_SLOW)); // R7

endmodule

// File: rtl/jafifo_core.sv
module jafifo_core #(
  parameter int DEPTH      = 32,
  parameter int CTR_MARGIN = 4,
  parameter int AW         = 5,
  parameter int FW         = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_bit,
  input  logic          rd_tick,
  input  logic          ctr_req,
  input  logic          ctr_en,
  output logic [FW-1:0] fill_q,
  output logic          out_bit,
  output logic          out_tick,
  output logic          ovr_ev,
  output logic          und_ev
);

  localparam logic [FW-1:0] FULL    = FW'(DEPTH);
  localparam logic [FW-1:0] HALF    = FW'(DEPTH / 2);
  localparam logic [FW-1:0] CTR_LO  = FW'(CTR_MARGIN);
  localparam logic [FW-1:0] CTR_HI  = FW'(DEPTH - CTR_MARGIN);

  logic          mem [DEPTH];
  logic [AW:0]   wr_q, rd_q, wr_n, rd_n;
  logic          rd_do, ctr_act;

  always_comb begin
    und_ev  = rd_tick && (fill_q == '0);
    ovr_ev  = in_valid && !rd_tick && (fill_q == FULL);
    rd_do   = rd_tick && (fill_q != '0);
    ctr_act = ctr_req || (ctr_en && (fill_q < CTR_LO || fill_q > CTR_HI));
    wr_n    = wr_q + {{AW{1'b0}}, in_valid};
    rd_n    = rd_q + {{AW{1'b0}}, rd_do} + {{AW{1'b0}}, ovr_ev};
    if (ctr_act) rd_n = wr_n - HALF;
  end

  // Storage: write port without reset so a block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (in_valid) mem[wr_q[AW-1:0]] <= in_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= '0;
      rd_q     <= '0;
      fill_q   <= '0;
      out_bit  <= 1'b0;
      out_tick <= 1'b0;
    end else begin
      wr_q     <= wr_n;
      rd_q     <= rd_n;
      fill_q   <= wr_n - rd_n;
      out_tick <= rd_tick;
      if (rd_do) out_bit <= mem[rd_q[AW-1:0]];
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill_q <= FULL); // R4
  AST_CENTER_HALF: assert property (@(posedge clk) disable iff (rst)
    ctr_act |=> (fill_q == HALF)); // R5
  AST_UNDER_HOLD: assert property (@(posedge clk) disable iff (rst)
    und_ev |=> $stable(out_bit)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ovr_ev && !ctr_act) |=> (fill_q == FULL)); // R4

endmodule

// File: rtl/jafifo_top.sv
module jafifo_top
  import jafifo_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int DIV_NOM    = 8,
  parameter int CTR_MARGIN = 4,
  parameter int LIM_MARGIN = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_bit,
  input  logic                   cfg_we,
  input  logic [7:0]             cfg_wdata,
  output logic [7:0]             cfg_rdata,
  input  logic                   sts_clr_we,
  input  logic [1:0]             sts_clr,
  output logic [1:0]             sts,
  output logic [$clog2(DEPTH):0] fill,
  output logic                   out_bit,
  output logic                   out_tick,
  output logic                   out_clk,
  output logic                   irq
);

  localparam int AW = $clog2(DEPTH);
  localparam int FW = AW + 1;

  jaf_cfg_t      cfg_q;
  logic          ctr_pulse, ovr_ev, und_ev, rd_tick;
  logic [FW-1:0] fill_q;

  jafifo_regs u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sts_clr_we(sts_clr_we), .sts_clr(sts_clr), .ovr_ev(ovr_ev), .und_ev(und_ev),
    .cfg_q(cfg_q), .ctr_pulse(ctr_pulse), .sts_q(sts), .irq(irq)
  );

  jafifo_div #(.DIV_NOM(DIV_NOM), .DEPTH(DEPTH), .LIM_MARGIN(LIM_MARGIN), .FW(FW)) u_div (
    .clk(clk), .rst(rst), .lim_en(cfg_q.lim_en), .fill_q(fill_q),
    .rd_tick(rd_tick), .out_clk(out_clk)
  );

  jafifo_core #(.DEPTH(DEPTH), .CTR_MARGIN(CTR_MARGIN), .AW(AW), .FW(FW)) u_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .rd_tick(rd_tick),
    .ctr_req(ctr_pulse), .ctr_en(cfg_q.ctr_en), .fill_q(fill_q), .out_bit(out_bit),
    .out_tick(out_tick), .ovr_ev(ovr_ev), .und_ev(und_ev)
  );

  assign cfg_rdata = {4'b0000, cfg_q};
  assign fill      = fill_q;

endmodule

// File: tb/jafifo_top_tb_top.sv
module jafifo_top_tb_top;

  localparam int DEPTH = 32;
  localparam int DIV   = 8;
  localparam int HMAX  = 16384;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic sts_clr_we = 1'b0;
  logic [1:0] sts_clr = 2'b00;
  logic [7:0] cfg_rdata;
  logic [1:0] sts;
  logic [5:0] fill;
  logic out_bit, out_tick, out_clk, irq;

  always #10 clk = ~clk;

  jafifo_top #(.DEPTH(DEPTH), .DIV_NOM(DIV), .CTR_MARGIN(4), .LIM_MARGIN(1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sts_clr_we(sts_clr_we),
    .sts_clr(sts_clr), .sts(sts), .fill(fill), .out_bit(out_bit),
    .out_tick(out_tick), .out_clk(out_clk), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit hist [HMAX];
  int m_wr = 0, m_rd = 0;
  logic [3:0] m_cfg = 4'b0001;
  logic [1:0] m_sts = 2'b00;
  bit pend = 0;
  int cur_p = -1, phase = 0;
  bit last_out = 0, last_ok = 1;
  int g_per = 0, g_jit = 0, wc = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Model of one clock edge, evaluated at the following falling edge.
  task automatic step();
    int f;
    bit tk, und, ovr, ctr, via_pulse;
    logic [1:0] clr;
    f   = m_wr - m_rd;
    tk  = out_tick;
    und = tk && (f == 0);
    ovr = in_valid && !tk && (f == DEPTH);
    if (tk) begin
      if (f > 0) begin
        if (m_rd >= 0) begin
          chk(out_bit == hist[m_rd], "R2 out_bit", out_bit, hist[m_rd]);
          last_out = hist[m_rd]; last_ok = 1;
        end else last_ok = 0;
        m_rd++;
      end else if (last_ok) begin
        chk(out_bit == last_out, "R3 hold", out_bit, last_out);
      end
      if (cur_p > 0) chk(phase + 1 == cur_p, "R7 period", phase + 1, cur_p);
      if (m_cfg[0] && f <= 1)       cur_p = DIV + 1;
      else if (m_cfg[0] && f >= 31) cur_p = DIV - 1;
      else                          cur_p = DIV;
      phase = 0;
    end else phase++;
    if (cur_p > 0)
      chk(out_clk == (phase < cur_p - DIV / 2), "R11 out_clk", out_clk, phase < cur_p - DIV / 2);
    if (in_valid) begin
      hist[m_wr] = in_bit; m_wr++;
      if (ovr) m_rd++;
    end
    via_pulse = pend;
    ctr = pend || (m_cfg[3] && (f < 4 || f > 28));
    if (ctr) m_rd = m_wr - DEPTH / 2;
    pend = cfg_we && cfg_wdata[3] && !m_cfg[3];
    if (cfg_we) m_cfg = cfg_wdata[3:0];
    clr = sts_clr_we ? sts_clr : 2'b00;
    m_sts = (m_sts & ~clr) | {und, ovr};
    if (via_pulse)  chk(int'(fill) == m_wr - m_rd, "R6 fill", fill, m_wr - m_rd);
    else if (ctr)   chk(int'(fill) == m_wr - m_rd, "R5 fill", fill, m_wr - m_rd);
    else            chk(int'(fill) == m_wr - m_rd, "R2 fill", fill, m_wr - m_rd);
    chk(sts == m_sts, "R8 sts", sts, m_sts);
    chk(irq == |(m_sts & {m_cfg[2], m_cfg[1]}), "R9 irq", irq, |(m_sts & {m_cfg[2], m_cfg[1]}));
    chk(cfg_rdata == {4'b0000, m_cfg}, "R10 cfg_rdata", cfg_rdata, {4'b0000, m_cfg});
  endtask

  task automatic cyc();
    int j;
    @(negedge clk);
    step();
    cfg_we = 1'b0; sts_clr_we = 1'b0; sts_clr = 2'b00;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    in_bit = lfsr[0];
    if (g_per == 0) in_valid = 1'b0;
    else if (wc == 0) begin
      in_valid = 1'b1;
      j = (g_jit > 0) ? (int'(lfsr[7:1]) % (2 * g_jit + 1)) - g_jit : 0;
      wc = g_per - 1 + j;
      if (wc < 0) wc = 0;
    end else begin
      in_valid = 1'b0; wc--;
    end
  endtask

  task automatic run(input int n, input int per, input int jit);
    g_per = per; g_jit = jit;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wcfg(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 8'h01, "R1 cfg", cfg_rdata, 1);
    chk(fill == 0, "R1 fill", fill, 0);
    chk(sts == 0 && irq == 0 && out_bit == 0, "R1 flags", {sts, irq, out_bit}, 0);
    rst = 1'b0;
    wcfg(8'h00);
    run(20, 1, 0);
    run(2000, 8, 2);
    run(2000, 7, 0);
    chk(sts[0] == 1'b1, "R4 overrun seen", sts[0], 1);
    wcfg(8'h02);
    run(50, 7, 0);
    chk(irq == 1'b1, "R9 ovr irq", irq, 1);
    run(10, 9, 0);
    sts_clr_we = 1'b1; sts_clr = 2'b01;
    cyc();
    chk(sts[0] == 1'b0, "R8 cleared", sts[0], 0);
    wcfg(8'h01);
    run(3000, 9, 0);
    run(3000, 7, 0);
    wcfg(8'h08);
    run(3000, 7, 1);
    wcfg(8'h0C);
    run(1500, 9, 1);
    wcfg(8'h00);
    run(300, 0, 0);
    chk(sts[1] == 1'b1, "R3 underrun seen", sts[1], 1);
    wcfg(8'h04);
    chk(irq == 1'b1, "R9 und irq", irq, 1);
    wcfg(8'h00);
    g_per = 1; g_jit = 0;
    while (m_wr - m_rd < 22) cyc();
    g_per = 0;
    wcfg(8'h08);
    cyc();
    chk(fill == 16, "R6 manual center", fill, 16);
    g_per = 1;
    repeat (6) cyc();
    g_per = 0;
    wcfg(8'h08);
    cyc();
    chk(fill != 16, "R6 no repeat center", fill, 17);
    wcfg(8'hF3);
    chk(cfg_rdata == 8'h03, "R10 reserved", cfg_rdata, 3);
    run(200, 8, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule